// File: doc/BRIEF.md
# Packet PIO Word Mover with Odd-Byte Handling

This block performs a single programmed-I/O data phase of a packet command on a device whose data port is 16 bits wide. When started, it reads the device's requested byte count from two 8-bit count registers. It then limits the transfer to the number of bytes the host still expects. Data moves as 16-bit words between the device data port and a byte-addressed host buffer. If the count is odd, one final single byte is moved. On a device-to-buffer phase, any bytes the device offers beyond the host's limit are read from the port and thrown away. Each phase ends with a settle delay and a one-cycle `done` pulse. At that point the updated residual count is available.

Both data paths on the device side and both on the buffer side are valid/ready streams. A word moves on a clock edge where valid and ready are both high. A valid that has been raised stays high, with its address, lanes and data unchanged, until ready is seen. Ready may be lowered at any time. For a buffer read, the returned data is taken in the same cycle as the handshake. The count registers use plain one-cycle read strobes, and `reg_rdata` is sampled in the strobe cycle. The block has a second job for commands run by an external DMA engine. A `dma_end` pulse applies the completion rule for the residual without any port activity.

Top module: `pkt_data_mover`

## Requirements
- R1: The device byte count is `reg_rdata` sampled under `reg_hi_rd` shifted left by 8, plus `reg_rdata` sampled under `reg_lo_rd`. Each phase issues exactly one low strobe, then exactly one high strobe, each lasting one cycle and never both at once.
- R2: The phase moves N = min(`residual_in`, device count) bytes. At `done`, `residual_out` equals `residual_in` − N, and `data_moved` is 1 whenever the device count is non-zero.
- R3: Whole words are moved first, floor(N/2) of them, at buffer addresses `buf_base` + 2k with lanes `11`. Bits [7:0] belong to the lower address and bits [15:8] to the next one.
- R4: In a device-to-buffer phase with odd N, one more device word is read. Only its bits [7:0] are written, at `buf_base` + N − 1 with lanes `01`. Nothing is written at `buf_base` + N.
- R5: In a buffer-to-device phase with odd N, the last buffer read uses lanes `01`, and the device receives {8'h00, byte}. No buffer read ever touches an address outside [`buf_base`, `buf_base` + N). A read request's lanes are always `11` or `01`.
- R6: In a device-to-buffer phase, the device port is read exactly ceil(count/2) times. Words beyond N bytes are discarded and never reach the buffer.
- R7: In a buffer-to-device phase, exactly ceil(N/2) words are written to the device. No surplus words are written.
- R8: `done` is a one-cycle pulse. It comes at least `SETTLE_CYC` cycles after the last data handshake of the phase.
- R9: A device count of zero ends the phase within six cycles of `start`. It causes no data or buffer handshake, leaves `residual_out` equal to `residual_in`, and clears `data_moved`. While idle, no data-side valid or ready is driven.
- R10: A `dma_end` pulse while idle updates both status outputs in the next cycle. With `dma_fault` low, `residual_out` becomes 0 and `data_moved` becomes 1. With `dma_fault` high, `residual_out` becomes `residual_in` and `data_moved` becomes 0.
- R11: Under any pattern of back-pressure, a raised valid on `buf_wr`, `buf_rd` or `dev_wr` holds its payload until accepted. The words arrive complete and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a phase (taken while idle) |
| dir_in | input | 1 | 1: device to buffer, 0: buffer to device |
| residual_in | input | RES_W | Bytes the host still expects |
| buf_base | input | ADDR_W | Buffer byte address of the first byte |
| dma_end | input | 1 | DMA command completed (pulse, idle only) |
| dma_fault | input | 1 | DMA completed with a transfer error |
| reg_lo_rd | output | 1 | Read strobe, low count register |
| reg_hi_rd | output | 1 | Read strobe, high count register |
| reg_rdata | input | 8 | Count register data, valid in strobe cycle |
| dev_rd_valid | input | 1 | Device data word available |
| dev_rd_ready | output | 1 | Block takes a device word |
| dev_rd_data | input | 16 | Device data word |
| dev_wr_valid | output | 1 | Word offered to the device |
| dev_wr_ready | input | 1 | Device accepts the word |
| dev_wr_data | output | 16 | Word to the device |
| buf_wr_valid | output | 1 | Buffer write request |
| buf_wr_ready | input | 1 | Buffer accepts the write |
| buf_wr_addr | output | ADDR_W | Byte address of lane 0 |
| buf_wr_data | output | 16 | Write data, [7:0] at the address |
| buf_wr_be | output | 2 | Lane enables (`11` or `01`) |
| buf_rd_valid | output | 1 | Buffer read request |
| buf_rd_ready | input | 1 | Buffer returns data this cycle |
| buf_rd_addr | output | ADDR_W | Byte address of lane 0 |
| buf_rd_be | output | 2 | Lanes requested (`11` or `01`) |
| buf_rd_data | input | 16 | Read data, [7:0] from the address |
| busy | output | 1 | Phase in progress |
| done | output | 1 | One-cycle end-of-phase pulse |
| residual_out | output | RES_W | Updated residual |
| data_moved | output | 1 | Data-transferred flag |

## Verification
Random phases pair device counts with host residuals that are both below and above them, in both directions, with even and odd values. This separates three behaviours: the clamp, the odd-tail path, and the drain path. Directed phases cover cases that random draws rarely hit. A count with a non-zero high byte exposes a swapped or dropped register byte. A zero count must produce no port traffic. A zero residual with a non-zero count must move nothing while still draining on reads. Light versus heavy ready probabilities tell a correct hold-until-accepted stream apart from one that drops or repeats words. The two DMA completions, with and without a fault, tell the cleared residual apart from the preserved one.

// File: rtl/pdm_pkg.sv
`timescale 1ns/1ps
package pdm_pkg;
  localparam int PDM_REG_W  = 8;
  localparam int PDM_BC_W   = 2 * PDM_REG_W;
  localparam int PDM_WORD_W = 16;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CNT_LO,
    PH_CNT_HI,
    PH_PLAN,
    PH_MOVE,
    PH_SETTLE
  } phase_t;

  typedef enum logic [1:0] {
    LANE_NONE = 2'b00,
    LANE_LOW  = 2'b01,
    LANE_BOTH = 2'b11
  } lanes_t;
endpackage

// File: rtl/pdm_plan.sv
`timescale 1ns/1ps
module pdm_plan
  import pdm_pkg::*;
#(
  parameter int RES_W = 24
) (
  input  logic [PDM_BC_W-1:0] dev_bytes,
  input  logic [RES_W-1:0]    residual,
  input  logic                to_buf,
  output logic [PDM_BC_W-1:0] xfer_bytes,
  output logic [PDM_BC_W-1:0] full_words,
  output logic                odd_tail,
  output logic [PDM_BC_W-1:0] total_words
);
  localparam int CMP_W = (RES_W > PDM_BC_W) ? RES_W : PDM_BC_W;

  logic [CMP_W-1:0] res_x;
  logic [CMP_W-1:0] dev_x;
  logic [CMP_W-1:0] min_x;
  logic [PDM_BC_W-1:0] dev_words;

  always_comb begin
    res_x      = CMP_W'(residual);
    dev_x      = CMP_W'(dev_bytes);
    min_x      = (res_x < dev_x) ? res_x : dev_x;
    xfer_bytes = min_x[PDM_BC_W-1:0];
    full_words = xfer_bytes >> 1;
    odd_tail   = xfer_bytes[0];
    dev_words  = (dev_bytes >> 1) + PDM_BC_W'(dev_bytes[0]);
  end

  generate
    if (1) begin : g_words
      always_comb begin
        if (to_buf) total_words = dev_words;
        else        total_words = full_words + PDM_BC_W'(odd_tail);
      end
    end
  endgenerate
endmodule

// File: rtl/pdm_slot.sv
`timescale 1ns/1ps
module pdm_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (in_valid && in_ready) begin
        full_q <= 1'b1;
        data_q <= in_data;
      end else if (out_ready) begin
        full_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pdm_seq.sv
`timescale 1ns/1ps
module pdm_seq
  import pdm_pkg::*;
#(
  parameter int RES_W      = 24,
  parameter int ADDR_W     = 16,
  parameter int SETTLE_CYC = 50
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 dir_in,
  input  logic [RES_W-1:0]     residual_in,
  input  logic [ADDR_W-1:0]    buf_base,
  input  logic                 dma_end,
  input  logic                 dma_fault,
  input  logic [PDM_REG_W-1:0] reg_rdata,
  output logic                 reg_lo_rd,
  output logic                 reg_hi_rd,
  output logic [PDM_BC_W-1:0]  plan_dev,
  output logic [RES_W-1:0]     plan_res,
  output logic                 to_buf,
  input  logic [PDM_BC_W-1:0]  plan_xfer,
  input  logic [PDM_BC_W-1:0]  plan_full,
  input  logic                 plan_odd,
  input  logic [PDM_BC_W-1:0]  plan_total,
  output logic                 issue_want,
  output logic [ADDR_W-1:0]    issue_addr,
  output logic [1:0]           issue_lanes,
  input  logic                 issue_fire,
  input  logic                 slot_busy,
  output logic                 busy,
  output logic                 done,
  output logic [RES_W-1:0]     residual_out,
  output logic                 data_moved
);
  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

  phase_t                 ph;
  logic [PDM_REG_W-1:0]   lo_q;
  logic [PDM_REG_W-1:0]   hi_q;
  logic [RES_W-1:0]       res_q;
  logic [ADDR_W-1:0]      base_q;
  logic                   dir_q;
  logic [PDM_BC_W-1:0]    xfer_q;
  logic [PDM_BC_W-1:0]    full_q;
  logic                   odd_q;
  logic [PDM_BC_W-1:0]    total_q;
  logic [PDM_BC_W-1:0]    idx;
  logic [CNT_W-1:0]       settle_cnt;

  assign plan_dev   = {hi_q, lo_q};
  assign plan_res   = res_q;
  assign to_buf     = dir_q;
  assign busy       = (ph != PH_IDLE);
  assign reg_lo_rd  = (ph == PH_CNT_LO);
  assign reg_hi_rd  = (ph == PH_CNT_HI);
  assign issue_want = (ph == PH_MOVE) && (idx != total_q);
  assign issue_addr = base_q + ADDR_W'({idx, 1'b0});

  always_comb begin
    if (idx < full_q)                 issue_lanes = LANE_BOTH;
    else if ((idx == full_q) && odd_q) issue_lanes = LANE_LOW;
    else                              issue_lanes = LANE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph           <= PH_IDLE;
      lo_q         <= '0;
      hi_q         <= '0;
      res_q        <= '0;
      base_q       <= '0;
      dir_q        <= 1'b0;
      xfer_q       <= '0;
      full_q       <= '0;
      odd_q        <= 1'b0;
      total_q      <= '0;
      idx          <= '0;
      settle_cnt   <= '0;
      done         <= 1'b0;
      residual_out <= '0;
      data_moved   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (ph)
        PH_IDLE: begin
          if (start) begin
            ph         <= PH_CNT_LO;
            dir_q      <= dir_in;
            res_q      <= residual_in;
            base_q     <= buf_base;
            data_moved <= 1'b0;
          end else if (dma_end) begin
            residual_out <= dma_fault ? residual_in : '0;
            data_moved   <= !dma_fault;
          end
        end
        PH_CNT_LO: begin
          lo_q <= reg_rdata;
          ph   <= PH_CNT_HI;
        end
        PH_CNT_HI: begin
          hi_q <= reg_rdata;
          ph   <= PH_PLAN;
        end
        PH_PLAN: begin
          xfer_q  <= plan_xfer;
          full_q  <= plan_full;
          odd_q   <= plan_odd;
          total_q <= plan_total;
          idx     <= '0;
          if (plan_dev == '0) begin
            done         <= 1'b1;
            residual_out <= res_q;
            data_moved   <= 1'b0;
            ph           <= PH_IDLE;
          end else begin
            ph <= PH_MOVE;
          end
        end
        PH_MOVE: begin
          if (issue_fire) idx <= idx + 1'b1;
          if ((idx == total_q) && !slot_busy) begin
            settle_cnt <= '0;
            ph         <= PH_SETTLE;
          end
        end
        PH_SETTLE: begin
          if (settle_cnt == CNT_W'(SETTLE_CYC - 1)) begin
            done         <= 1'b1;
            residual_out <= res_q - RES_W'(xfer_q);
            data_moved   <= 1'b1;
            ph           <= PH_IDLE;
          end else begin
            settle_cnt <= settle_cnt + 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_data_mover.sv
`timescale 1ns/1ps
module pkt_data_mover
  import pdm_pkg::*;
#(
  parameter int RES_W      = 24,
  parameter int ADDR_W     = 16,
  parameter int SETTLE_CYC = 50
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  dir_in,
  input  logic [RES_W-1:0]      residual_in,
  input  logic [ADDR_W-1:0]     buf_base,
  input  logic                  dma_end,
  input  logic                  dma_fault,
  output logic                  reg_lo_rd,
  output logic                  reg_hi_rd,
  input  logic [7:0]            reg_rdata,
  input  logic                  dev_rd_valid,
  output logic                  dev_rd_ready,
  input  logic [15:0]           dev_rd_data,
  output logic                  dev_wr_valid,
  input  logic                  dev_wr_ready,
  output logic [15:0]           dev_wr_data,
  output logic                  buf_wr_valid,
  input  logic                  buf_wr_ready,
  output logic [ADDR_W-1:0]     buf_wr_addr,
  output logic [15:0]           buf_wr_data,
  output logic [1:0]            buf_wr_be,
  output logic                  buf_rd_valid,
  input  logic                  buf_rd_ready,
  output logic [ADDR_W-1:0]     buf_rd_addr,
  output logic [1:0]            buf_rd_be,
  input  logic [15:0]           buf_rd_data,
  output logic                  busy,
  output logic                  done,
  output logic [RES_W-1:0]      residual_out,
  output logic                  data_moved
);
  localparam int SLOT_W = ADDR_W + 2 + 1 + PDM_WORD_W;

  logic [PDM_BC_W-1:0] plan_dev, plan_xfer, plan_full, plan_total;
  logic [RES_W-1:0]    plan_res;
  logic                plan_odd;
  logic                to_buf;
  logic                issue_want, issue_fire;
  logic [ADDR_W-1:0]   issue_addr;
  logic [1:0]          issue_lanes;

  logic                slot_in_ready, slot_out_valid, slot_out_ready;
  logic [SLOT_W-1:0]   slot_in, slot_out;
  logic [15:0]         src_word;
  logic                issue_keep;

  logic [ADDR_W-1:0]   out_addr;
  logic [1:0]          out_lanes;
  logic                out_keep;
  logic [15:0]         out_word;

  pdm_seq #(
    .RES_W(RES_W), .ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_in(dir_in),
    .residual_in(residual_in), .buf_base(buf_base),
    .dma_end(dma_end), .dma_fault(dma_fault), .reg_rdata(reg_rdata),
    .reg_lo_rd(reg_lo_rd), .reg_hi_rd(reg_hi_rd),
    .plan_dev(plan_dev), .plan_res(plan_res), .to_buf(to_buf),
    .plan_xfer(plan_xfer), .plan_full(plan_full), .plan_odd(plan_odd),
    .plan_total(plan_total), .issue_want(issue_want),
    .issue_addr(issue_addr), .issue_lanes(issue_lanes),
    .issue_fire(issue_fire), .slot_busy(slot_out_valid),
    .busy(busy), .done(done), .residual_out(residual_out),
    .data_moved(data_moved)
  );

  pdm_plan #(.RES_W(RES_W)) u_plan (
    .dev_bytes(plan_dev), .residual(plan_res), .to_buf(to_buf),
    .xfer_bytes(plan_xfer), .full_words(plan_full), .odd_tail(plan_odd),
    .total_words(plan_total)
  );

  // Source side: device port on inbound phases, buffer reads on outbound.
  assign dev_rd_ready = to_buf && issue_want && slot_in_ready;
  assign buf_rd_valid = !to_buf && issue_want && !slot_out_valid;
  assign buf_rd_addr  = issue_addr;
  assign buf_rd_be    = issue_lanes;
  assign issue_fire   = to_buf ? (dev_rd_valid && dev_rd_ready)
                               : (buf_rd_valid && buf_rd_ready);
  assign issue_keep   = (issue_lanes != LANE_NONE);

  always_comb begin
    src_word = to_buf ? dev_rd_data : buf_rd_data;
    if (issue_lanes == LANE_LOW) src_word = {8'h00, src_word[7:0]};
  end

  assign slot_in = {issue_addr, issue_lanes, issue_keep, src_word};

  pdm_slot #(.W(SLOT_W)) u_slot (
    .clk(clk), .rst_n(rst_n),
    .in_valid(issue_fire), .in_ready(slot_in_ready), .in_data(slot_in),
    .out_valid(slot_out_valid), .out_ready(slot_out_ready),
    .out_data(slot_out)
  );

  assign {out_addr, out_lanes, out_keep, out_word} = slot_out;

  // Sink side: buffer writes (discarded words drop here) or device writes.
  assign buf_wr_valid   = to_buf && slot_out_valid && out_keep;
  assign buf_wr_addr    = out_addr;
  assign buf_wr_be      = out_lanes;
  assign buf_wr_data    = out_word;
  assign dev_wr_valid   = !to_buf && slot_out_valid;
  assign dev_wr_data    = out_word;
  assign slot_out_ready = to_buf ? (out_keep ? buf_wr_ready : 1'b1)
                                 : dev_wr_ready;
endmodule

// File: rtl/pdm_chk.sv
`timescale 1ns/1ps
module pdm_chk #(
  parameter int RES_W  = 24,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              dma_end,
  input logic              dma_fault,
  input logic              busy,
  input logic              done,
  input logic [RES_W-1:0]  residual_out,
  input logic              data_moved,
  input logic              reg_lo_rd,
  input logic              reg_hi_rd,
  input logic              dev_rd_ready,
  input logic              dev_wr_valid,
  input logic              dev_wr_ready,
  input logic [15:0]       dev_wr_data,
  input logic              buf_wr_valid,
  input logic              buf_wr_ready,
  input logic [ADDR_W-1:0] buf_wr_addr,
  input logic [15:0]       buf_wr_data,
  input logic [1:0]        buf_wr_be,
  input logic              buf_rd_valid,
  input logic              buf_rd_ready,
  input logic [ADDR_W-1:0] buf_rd_addr,
  input logic [1:0]        buf_rd_be
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_lo_rd && reg_hi_rd)); // R1
  AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_hi_rd |-> $past(reg_lo_rd)); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(dev_rd_ready || dev_wr_valid || buf_wr_valid || buf_rd_valid)); // R9
  AST_RD_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_valid |-> (buf_rd_be == 2'b11 || buf_rd_be == 2'b01)); // R5
  AST_DMA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && dma_end && !dma_fault) |=> (residual_out == '0 && data_moved)); // R10
  AST_BUFWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr_valid && !buf_wr_ready) |=> (buf_wr_valid && $stable(buf_wr_addr) && $stable(buf_wr_data) && $stable(buf_wr_be))); // R11
  AST_DEVWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr_valid && !dev_wr_ready) |=> (dev_wr_valid && $stable(dev_wr_data))); // R11
  AST_BUFRD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd_valid && !buf_rd_ready) |=> (buf_rd_valid && $stable(buf_rd_addr) && $stable(buf_rd_be))); // R11
endmodule

bind pkt_data_mover pdm_chk #(.RES_W(RES_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dma_end(dma_end),
  .dma_fault(dma_fault), .busy(busy), .done(done),
  .residual_out(residual_out), .data_moved(data_moved),
  .reg_lo_rd(reg_lo_rd), .reg_hi_rd(reg_hi_rd),
  .dev_rd_ready(dev_rd_ready), .dev_wr_valid(dev_wr_valid),
  .dev_wr_ready(dev_wr_ready), .dev_wr_data(dev_wr_data),
  .buf_wr_valid(buf_wr_valid), .buf_wr_ready(buf_wr_ready),
  .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data),
  .buf_wr_be(buf_wr_be), .buf_rd_valid(buf_rd_valid),
  .buf_rd_ready(buf_rd_ready), .buf_rd_addr(buf_rd_addr),
  .buf_rd_be(buf_rd_be)
);

// File: tb/tb_pkt_data_mover.sv
`timescale 1ns/1ps
module tb_pkt_data_mover;
  localparam int RES_W  = 24;
  localparam int ADDR_W = 16;
  localparam int SETTLE = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, dir_in = 1'b0, dma_end = 1'b0, dma_fault = 1'b0;
  logic [RES_W-1:0]  residual_in = '0;
  logic [ADDR_W-1:0] buf_base = '0;
  logic reg_lo_rd, reg_hi_rd;
  logic [7:0] reg_rdata = '0;
  logic dev_rd_valid = 1'b0, dev_rd_ready;
  logic [15:0] dev_rd_data = '0;
  logic dev_wr_valid, dev_wr_ready = 1'b0;
  logic [15:0] dev_wr_data;
  logic buf_wr_valid, buf_wr_ready = 1'b0;
  logic [ADDR_W-1:0] buf_wr_addr, buf_rd_addr;
  logic [15:0] buf_wr_data;
  logic [1:0] buf_wr_be, buf_rd_be;
  logic buf_rd_valid, buf_rd_ready = 1'b0;
  logic [15:0] buf_rd_data = '0;
  logic busy, done, data_moved;
  logic [RES_W-1:0] residual_out;

  pkt_data_mover #(.RES_W(RES_W), .ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE)) dut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0]  mem [0:4095];
  logic [15:0] dev_words [0:511];
  logic [15:0] cur_bc = '0;
  int prob = 100;
  int rd_widx, wr_cnt, bw_cnt, br_cnt, lo_cnt, hi_cnt, oob;
  int ph_base = 0, ph_xfer = 0;
  realtime last_hs = 0;

  function automatic logic [15:0] pat(int k);
    return 16'(k * 16'h0107 + 16'h3A5C);
  endfunction
  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction
  function automatic int ceil2(int a);
    return (a + 1) / 2;
  endfunction
  function automatic logic [7:0] in_byte(int j);
    logic [15:0] w;
    w = pat(j / 2);
    return (j % 2) ? w[15:8] : w[7:0];
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // Environment: device port, count registers and buffer memory.
  initial begin
    forever begin
      @(negedge clk);
      dev_rd_valid = (($urandom % 100) < prob);
      dev_rd_data  = pat(rd_widx);
      dev_wr_ready = (($urandom % 100) < prob);
      buf_wr_ready = (($urandom % 100) < prob);
      buf_rd_ready = (($urandom % 100) < prob);
      reg_rdata    = reg_lo_rd ? cur_bc[7:0] : (reg_hi_rd ? cur_bc[15:8] : 8'h00);
      buf_rd_data  = {mem[int'(buf_rd_addr) + 1], mem[int'(buf_rd_addr)]};
      #1;
      lo_cnt += int'(reg_lo_rd);
      hi_cnt += int'(reg_hi_rd);
      if (dev_rd_valid && dev_rd_ready) begin rd_widx++; last_hs = $realtime; end
      if (dev_wr_valid && dev_wr_ready) begin
        if (wr_cnt < 512) dev_words[wr_cnt] = dev_wr_data;
        wr_cnt++; last_hs = $realtime;
      end
      if (buf_rd_valid && buf_rd_ready) begin
        if (int'(buf_rd_addr) < ph_base ||
            int'(buf_rd_addr) + int'(buf_rd_be[1]) >= ph_base + ph_xfer) oob++;
        br_cnt++; last_hs = $realtime;
      end
      if (buf_wr_valid && buf_wr_ready) begin
        if (int'(buf_wr_addr) < ph_base ||
            int'(buf_wr_addr) + int'(buf_wr_be[1]) >= ph_base + ph_xfer) oob++;
        if (buf_wr_be[0]) mem[int'(buf_wr_addr)] = buf_wr_data[7:0];
        if (buf_wr_be[1]) mem[int'(buf_wr_addr) + 1] = buf_wr_data[15:8];
        bw_cnt++; last_hs = $realtime;
      end
    end
  end

  task automatic run_phase(input bit rd, input int res, input int bc,
                           input int base, input int pv, input string tag);
    int xfer, wd, bad, first_j;
    realtime t0;
    xfer = imin(res, bc);
    for (int i = base - 4; i < base + bc + 6; i++) mem[i] = rd ? 8'hEE : 8'($urandom);
    cur_bc = 16'(bc); prob = pv;
    rd_widx = 0; wr_cnt = 0; bw_cnt = 0; br_cnt = 0; lo_cnt = 0; hi_cnt = 0; oob = 0;
    ph_base = base; ph_xfer = xfer;
    @(negedge clk);
    dir_in = rd; residual_in = RES_W'(res); buf_base = ADDR_W'(base); start = 1'b1;
    t0 = $realtime;
    @(negedge clk);
    start = 1'b0;
    wd = 0;
    while (!done && wd < 20000) begin @(negedge clk); wd++; end
    chk(wd < 20000, "R8", {tag, " watchdog"}, wd, 0);
    chk(lo_cnt == 1 && hi_cnt == 1, "R1", {tag, " count strobes"}, lo_cnt * 10 + hi_cnt, 11);
    chk(residual_out == RES_W'(res - xfer), "R2", {tag, " residual"}, residual_out, res - xfer);
    chk(data_moved == (bc != 0), "R2", {tag, " data_moved"}, data_moved, bc != 0);
    if (bc == 0) begin
      chk(rd_widx + wr_cnt + bw_cnt + br_cnt == 0, "R9", {tag, " port traffic"},
          rd_widx + wr_cnt + bw_cnt + br_cnt, 0);
      chk(($realtime - t0) <= 6 * 8, "R9", {tag, " latency"}, longint'(($realtime - t0) / 8), 6);
    end else begin
      if (rd_widx + wr_cnt > 0)
        chk(($realtime - last_hs) >= SETTLE * 8, "R8", {tag, " settle"},
            longint'(($realtime - last_hs) / 8), SETTLE);
      chk(oob == 0, "R5", {tag, " buffer access outside range"}, oob, 0);
      if (rd) begin
        chk(rd_widx == ceil2(bc), "R6", {tag, " device reads"}, rd_widx, ceil2(bc));
        bad = 0; first_j = 0;
        for (int j = 0; j < xfer; j++)
          if (mem[base + j] != in_byte(j)) begin if (bad == 0) first_j = j; bad++; end
        chk(bad == 0, "R3", {tag, " buffer bytes"}, first_j, -1);
        chk(mem[base + xfer] == 8'hEE, "R4", {tag, " byte past end"}, mem[base + xfer], 8'hEE);
      end else begin
        chk(wr_cnt == ceil2(xfer), "R7", {tag, " device writes"}, wr_cnt, ceil2(xfer));
        bad = 0; first_j = 0;
        for (int k = 0; k < xfer / 2 && k < 512; k++)
          if (dev_words[k] != {mem[base + 2 * k + 1], mem[base + 2 * k]}) begin
            if (bad == 0) first_j = k; bad++;
          end
        chk(bad == 0, "R11", {tag, " device words"}, first_j, -1);
        if (xfer % 2 == 1)
          chk(dev_words[xfer / 2] == {8'h00, mem[base + xfer - 1]}, "R5", {tag, " odd tail"},
              dev_words[xfer / 2], {8'h00, mem[base + xfer - 1]});
      end
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd9127));
    rd_widx = 0; wr_cnt = 0; bw_cnt = 0; br_cnt = 0; lo_cnt = 0; hi_cnt = 0; oob = 0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && residual_out == 0 && !data_moved, "R9", "reset state",
        {busy, done, data_moved}, 0);
    chk(!dev_rd_ready && !dev_wr_valid && !buf_wr_valid && !buf_rd_valid, "R9",
        "idle ports", {dev_rd_ready, dev_wr_valid, buf_wr_valid, buf_rd_valid}, 0);

    run_phase(1, 100, 7, 16, 100, "R4 read odd");
    run_phase(1, 5, 10, 200, 60, "R6 read clamp+drain");
    run_phase(1, 1000, 259, 400, 100, "R1 read high byte");
    run_phase(1, 0, 6, 800, 100, "R6 read zero residual");
    run_phase(0, 9, 9, 1000, 100, "R5 write odd");
    run_phase(0, 7, 20, 1100, 50, "R7 write clamp");
    run_phase(0, 0, 6, 1200, 100, "R7 write zero residual");
    run_phase(1, 50, 0, 1300, 100, "R9 read zero count");
    run_phase(0, 50, 0, 1300, 100, "R9 write zero count");
    run_phase(1, 64, 64, 1400, 15, "R11 read backpressure");
    run_phase(0, 63, 64, 1500, 15, "R11 write backpressure");

    @(negedge clk);
    residual_in = 24'd77; dma_fault = 1'b0; dma_end = 1'b1;
    @(negedge clk);
    dma_end = 1'b0;
    chk(residual_out == 0 && data_moved, "R10", "dma clean", residual_out, 0);
    @(negedge clk);
    residual_in = 24'd77; dma_fault = 1'b1; dma_end = 1'b1;
    @(negedge clk);
    dma_end = 1'b0; dma_fault = 1'b0;
    chk(residual_out == 77 && !data_moved, "R10", "dma fault", residual_out, 77);

    for (int n = 0; n < 24; n++)
      run_phase(1'($urandom % 2), int'($urandom % 400), int'($urandom % 400),
                8 + int'($urandom % 1500), 30 + int'($urandom % 70), "R2 random");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL R8 global watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule